// File: doc/BRIEF.md
# Rectangular Blit Address Sequencer

This block produces the memory word addresses for a rectangular block transfer. It handles three read streams (A, B, C) and one write stream (D). Each stream has a byte pointer and a signed per-row skip. The block walks a rectangle of a programmed number of rows, each a programmed number of 16-bit words wide. The walk runs either ascending, from the first word forward, or descending, from the last word backward.

For every word, the block issues one memory request per enabled stream on a simple request/grant port. The reads go first and the destination write goes last. It advances only when a request is granted.

Software loads the block through one write port. It loads pointers, skips and the control word first, then writes the packed size word, and that write launches the walk. A busy flag covers the whole walk. Pointers are left at their advanced values, so a following walk can continue where the last one stopped.

Top module: `blit_addr_seq`

## Requirements
- R1: After reset, `busy` and `req_valid` are low and every pointer reads zero on `ptr_o`.
- R2: The size word is `wr_data[15:0]` written with `wr_sel`=9. Its bits 15:6 give the row count and bits 5:0 give the words per row, and a zero field means the maximum (1024 rows, 64 words). A walk makes exactly (enabled streams) × words × rows accesses.
- R3: Writing the size word while idle, with at least one stream enabled, raises `busy` on the next cycle. With no stream enabled, the walk does not start.
- R4: Within each word, enabled streams are served in the order A (`req_chan`=0), B (1), C (2), then D (3). `req_write` is high only for D, and disabled streams are never requested.
- R5: Ascending (control bit 4 clear): a stream's address grows by 2 after each of its granted words. After the last word of each row, its skip is also added. The skip is loaded with `wr_sel`=4..7 for A..D and is a signed 16-bit byte count whose bit 0 is ignored.
- R6: Descending (control bit 4 set): a stream's address drops by 2 per granted word, and its skip is subtracted after the last word of each row.
- R7: An ungranted request holds its channel, address and direction unchanged into the next cycle. State advances only on a grant.
- R8: `busy` stays high until the final access of the walk is granted and is low in the following cycle.
- R9: When a walk ends, the pointers hold their advanced values on `ptr_o`. A new walk started without reloading them continues from those values.
- R10: While `busy` is high, every register write (pointers `wr_sel`=0..3, skips, control `wr_sel`=8 with stream enables in bits 3:0 for A..D, and the size word) is ignored.
- R11: Pointer bit 0 is forced to zero on load, so every request address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select (0..3 pointers, 4..7 skips, 8 control, 9 size/start) |
| wr_data | input | ADDR_W | Register write data |
| busy | output | 1 | Walk in progress |
| req_valid | output | 1 | Memory request pending |
| req_write | output | 1 | Request is the destination write |
| req_chan | output | 2 | Stream of the pending request (0=A .. 3=D) |
| req_addr | output | ADDR_W | Byte address of the pending request |
| req_grant | input | 1 | Memory accepts the pending request this cycle |
| ptr_o | output | 4*ADDR_W | Current pointers, stream A in the low bits |

## Verification
Directed walks cover four cases:
- a full four-stream walk with a negative skip, which separates added from subtracted row skips;
- a descending two-stream walk, which separates the two directions;
- the two zero-field sizes, which show the maximum decodes of width and height independently;
- a walk with register writes injected mid-way.

Seeded random walks vary the stream subsets, direction, shape, pointers and skips, while grants are withheld at random. These walks expose errors in the channel order, row-end detection and hold-until-grant behaviour. A second walk without reloading the pointers distinguishes pointers that keep their end values from pointers that reload.

// File: rtl/blit_pkg.sv
package blit_pkg;

    localparam int NCH  = 4;
    localparam int CH_W = 2;
    localparam int CH_D = 3;

    // register select codes
    localparam int RS_PTR_BASE = 0;
    localparam int RS_MOD_BASE = 4;
    localparam int RS_CTRL     = 8;
    localparam int RS_SIZE     = 9;
    localparam int SEL_W       = 4;

    typedef struct packed {
        logic            desc;
        logic [NCH-1:0]  en;
    } ctrl_t;

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] idx;
    } pick_t;

    // lowest enabled stream whose index is at least `from`
    function automatic pick_t pick_from(logic [NCH-1:0] en, int from);
        pick_t r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (en[i] && (i >= from)) begin
                r.hit = 1'b1;
                r.idx = CH_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/blit_cfg_regs.sv
module blit_cfg_regs
    import blit_pkg::*;
#(
    parameter int H_BITS = 10,
    parameter int W_BITS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [15:0]       wr_data,
    input  logic              busy,
    output ctrl_t             ctrl,
    output logic [H_BITS-1:0] hlast,
    output logic [W_BITS-1:0] wlast,
    output logic [NCH-1:0]    ld_ptr,
    output logic [NCH-1:0]    ld_mod,
    output logic              start
);

    localparam int SZ_TOP = H_BITS + W_BITS - 1;

    logic wr_ok;
    logic sel_size;
    logic sel_ctrl;

    assign wr_ok    = wr_en && !busy;
    assign sel_size = wr_ok && (wr_sel == SEL_W'(RS_SIZE));
    assign sel_ctrl = wr_ok && (wr_sel == SEL_W'(RS_CTRL));
    assign start    = sel_size && (|ctrl.en);

    for (genvar i = 0; i < NCH; i++) begin : g_ld
        assign ld_ptr[i] = wr_ok && (wr_sel == SEL_W'(RS_PTR_BASE + i));
        assign ld_mod[i] = wr_ok && (wr_sel == SEL_W'(RS_MOD_BASE + i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            hlast <= '0;
            wlast <= '0;
        end else begin
            if (sel_ctrl) begin
                ctrl <= ctrl_t'(wr_data[NCH:0]);
            end
            if (sel_size) begin
                // field minus one: a zero field wraps to the maximum
                hlast <= wr_data[SZ_TOP:W_BITS] - H_BITS'(1);
                wlast <= wr_data[W_BITS-1:0] - W_BITS'(1);
            end
        end
    end

endmodule

// File: rtl/blit_chan_ptr.sv
module blit_chan_ptr #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_ptr,
    input  logic              ld_mod,
    input  logic [ADDR_W-1:1] wdata,
    input  logic              step,
    input  logic              row_end,
    input  logic              desc,
    output logic [ADDR_W-1:0] ptr
);

    localparam int WA_W = ADDR_W - 1;

    logic [WA_W-1:0] ptr_q;   // word address
    logic [15:1]     mod_q;   // skip in words
    logic [WA_W-1:0] mod_ext;
    logic [WA_W-1:0] delta;

    assign mod_ext = {{(WA_W - 15){mod_q[15]}}, mod_q};
    assign delta   = WA_W'(1) + (row_end ? mod_ext : '0);
    assign ptr     = {ptr_q, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            mod_q <= '0;
        end else begin
            if (ld_ptr) begin
                ptr_q <= wdata;
            end else if (step) begin
                ptr_q <= desc ? (ptr_q - delta) : (ptr_q + delta);
            end
            if (ld_mod) begin
                mod_q <= wdata[15:1];
            end
        end
    end

endmodule

// File: rtl/blit_walker.sv
module blit_walker
    import blit_pkg::*;
#(
    parameter int H_BITS = 10,
    parameter int W_BITS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [NCH-1:0]    en,
    input  logic [H_BITS-1:0] hlast,
    input  logic [W_BITS-1:0] wlast,
    input  logic              grant,
    output logic              busy,
    output logic [CH_W-1:0]   cur,
    output logic              row_end
);

    logic [W_BITS-1:0] col_q;
    logic [H_BITS-1:0] row_q;
    pick_t             first;
    pick_t             nxt;

    assign first   = pick_from(en, 0);
    assign nxt     = pick_from(en, int'(cur) + 1);
    assign row_end = (col_q == wlast);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cur   <= '0;
            col_q <= '0;
            row_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                cur   <= first.idx;
                col_q <= '0;
                row_q <= '0;
            end
        end else if (grant) begin
            if (nxt.hit) begin
                cur <= nxt.idx;
            end else begin
                cur <= first.idx;
                if (row_end) begin
                    col_q <= '0;
                    if (row_q == hlast) begin
                        busy <= 1'b0;
                    end else begin
                        row_q <= row_q + H_BITS'(1);
                    end
                end else begin
                    col_q <= col_q + W_BITS'(1);
                end
            end
        end
    end

endmodule

// File: rtl/blit_addr_seq.sv
module blit_addr_seq
    import blit_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int H_BITS = 10,
    parameter int W_BITS = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [3:0]            wr_sel,
    input  logic [ADDR_W-1:0]     wr_data,
    output logic                  busy,
    output logic                  req_valid,
    output logic                  req_write,
    output logic [1:0]            req_chan,
    output logic [ADDR_W-1:0]     req_addr,
    input  logic                  req_grant,
    output logic [4*ADDR_W-1:0]   ptr_o
);

    ctrl_t             ctrl;
    logic [H_BITS-1:0] hlast;
    logic [W_BITS-1:0] wlast;
    logic [NCH-1:0]    ld_ptr;
    logic [NCH-1:0]    ld_mod;
    logic              start;
    logic [CH_W-1:0]   cur;
    logic              row_end;
    logic [ADDR_W-1:0] ptr_arr [NCH];

    blit_cfg_regs #(
        .H_BITS (H_BITS),
        .W_BITS (W_BITS)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data[15:0]),
        .busy    (busy),
        .ctrl    (ctrl),
        .hlast   (hlast),
        .wlast   (wlast),
        .ld_ptr  (ld_ptr),
        .ld_mod  (ld_mod),
        .start   (start)
    );

    blit_walker #(
        .H_BITS (H_BITS),
        .W_BITS (W_BITS)
    ) u_walk (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .en      (ctrl.en),
        .hlast   (hlast),
        .wlast   (wlast),
        .grant   (req_grant),
        .busy    (busy),
        .cur     (cur),
        .row_end (row_end)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        blit_chan_ptr #(
            .ADDR_W (ADDR_W)
        ) u_ptr (
            .clk     (clk),
            .rst     (rst),
            .ld_ptr  (ld_ptr[ch]),
            .ld_mod  (ld_mod[ch]),
            .wdata   (wr_data[ADDR_W-1:1]),
            .step    (busy && req_grant && (cur == CH_W'(ch))),
            .row_end (row_end),
            .desc    (ctrl.desc),
            .ptr     (ptr_arr[ch])
        );
        assign ptr_o[ch*ADDR_W +: ADDR_W] = ptr_arr[ch];
    end

    assign req_valid = busy;
    assign req_chan  = cur;
    assign req_write = (cur == CH_W'(CH_D));
    assign req_addr  = ptr_arr[cur];

endmodule

// File: rtl/blit_addr_seq_chk.sv
module blit_addr_seq_chk
    import blit_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int H_BITS = 10,
    parameter int W_BITS = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_chan,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_grant,
    input logic              wr_en,
    input logic [3:0]        wr_sel,
    input logic [NCH-1:0]    en,
    input logic [H_BITS-1:0] hlast,
    input logic [W_BITS-1:0] wlast
);

    p_start_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_sel == 4'(RS_SIZE)) && !busy && (|en)) |=> busy);

    p_chan_enabled_r4: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> en[req_chan]);

    p_write_is_d_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |-> (req_chan == 2'(CH_D)));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_grant) |=>
            (req_valid && $stable(req_chan) && $stable(req_addr) && $stable(req_write)));

    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> ($stable(en) && $stable(hlast) && $stable(wlast)));

    p_aligned_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_addr[0] == 1'b0));

endmodule

bind blit_addr_seq blit_addr_seq_chk #(
    .ADDR_W (ADDR_W),
    .H_BITS (H_BITS),
    .W_BITS (W_BITS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_chan  (req_chan),
    .req_addr  (req_addr),
    .req_grant (req_grant),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .en        (ctrl.en),
    .hlast     (hlast),
    .wlast     (wlast)
);

// File: tb/blit_addr_seq_tb_top.sv
module blit_addr_seq_tb_top;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [3:0]    wr_sel;
    logic [AW-1:0] wr_data;
    logic          busy;
    logic          req_valid;
    logic          req_write;
    logic [1:0]    req_chan;
    logic [AW-1:0] req_addr;
    logic          req_grant;
    logic [4*AW-1:0] ptr_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // bench model state
    logic [AW-1:0] mp [4];
    logic [15:0]   mm [4];
    logic [3:0]    men;
    logic          mdesc;
    int            mcur, mcol, mrow, wl, hl;
    bit            mdone;

    always #2 clk = ~clk;   // 250 MHz

    blit_addr_seq dut_i (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
        .busy (busy), .req_valid (req_valid), .req_write (req_write), .req_chan (req_chan),
        .req_addr (req_addr), .req_grant (req_grant), .ptr_o (ptr_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wreg(input int sel, input logic [AW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 4'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_ptr(input int ch, input logic [AW-1:0] d);
        wreg(ch, d);
        mp[ch] = d & ~24'h1;            // R11: bit 0 dropped
    endtask

    task automatic load_mod(input int ch, input logic [15:0] d);
        wreg(4 + ch, {8'h0, d});
        mm[ch] = d & ~16'h1;            // R5: bit 0 ignored
    endtask

    function automatic int first_en(input logic [3:0] en, input int from);
        for (int i = from; i < 4; i++) if (en[i]) return i;
        return -1;
    endfunction

    task automatic model_step();
        bit re;
        logic [AW-1:0] d;
        int nx;
        re = (mcol == wl - 1);
        d  = 24'd2 + (re ? {{8{mm[mcur][15]}}, mm[mcur]} : 24'd0);
        mp[mcur] = mdesc ? (mp[mcur] - d) : (mp[mcur] + d);
        nx = first_en(men, mcur + 1);
        if (nx >= 0) mcur = nx;
        else begin
            mcur = first_en(men, 0);
            if (re) begin
                mcol = 0;
                if (mrow == hl - 1) mdone = 1; else mrow++;
            end else mcol++;
        end
    endtask

    // Runs one walk; inj adds register writes while busy (R10)
    task automatic run_blit(input logic [3:0] en, input logic desc, input logic [15:0] size,
                            input bit inj, input string tag);
        int cnt, exp_cnt, guard;
        bit did_sz, did_pt;
        men = en; mdesc = desc;
        wl = (size[5:0] == 0) ? 64 : int'(size[5:0]);
        hl = (size[15:6] == 0) ? 1024 : int'(size[15:6]);
        mcur = first_en(en, 0); mcol = 0; mrow = 0; mdone = 0;
        exp_cnt = $countones(en) * wl * hl;
        wreg(8, {19'h0, desc, en});
        wreg(9, {8'h0, size});
        chk(busy === 1'b1, "R3", {tag, " busy after start"}, longint'(busy), 1);
        cnt = 0; guard = 0; did_sz = 0; did_pt = 0;
        while (guard < 20000) begin
            guard++;
            if (mdone) begin
                chk(busy === 1'b0, "R8", {tag, " busy after final grant"}, longint'(busy), 0);
                break;
            end
            if (!busy) begin
                chk(0, "R8", {tag, " busy fell early at access"}, cnt, exp_cnt);
                break;
            end
            // R4 R5 R6 R7: channel, direction and address of the pending request
            chk(req_valid && req_chan == 2'(mcur) && req_write == (mcur == 3),
                "R4", {tag, " channel order"}, longint'(req_chan), mcur);
            chk(req_addr == mp[mcur], desc ? "R6" : "R5", {tag, " address"},
                longint'(req_addr), longint'(mp[mcur]));
            if (inj && cnt == 3 && !did_sz) begin
                wr_en = 1; wr_sel = 4'd9; wr_data = 24'h000041; did_sz = 1;
            end else if (inj && cnt == 5 && !did_pt) begin
                wr_en = 1; wr_sel = 4'd3; wr_data = 24'h123456; did_pt = 1;
            end
            req_grant = ($urandom % 4) != 0;
            if (req_grant) begin
                model_step();
                cnt++;
            end
            @(negedge clk);
            wr_en = 0;
            req_grant = 0;
        end
        chk(cnt == exp_cnt, inj ? "R10" : "R2", {tag, " access count"}, cnt, exp_cnt);
        for (int c = 0; c < 4; c++)
            chk(ptr_o[c*AW +: AW] == mp[c], inj ? "R10" : "R9", {tag, " end pointer"},
                longint'(ptr_o[c*AW +: AW]), longint'(mp[c]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; wr_en = 0; wr_sel = 0; wr_data = 0; req_grant = 0;
        for (int c = 0; c < 4; c++) begin mp[c] = 0; mm[c] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk(busy === 0 && req_valid === 0, "R1", "idle after reset", longint'({busy, req_valid}), 0);
        chk(ptr_o === '0, "R1", "pointers after reset", longint'(ptr_o[AW-1:0]), 0);

        // R3: no stream enabled -> no start
        wreg(8, 24'h0);
        wreg(9, 24'h0042);
        chk(busy === 0, "R3", "start ignored with no stream", longint'(busy), 0);

        // R4 R5: four streams, ascending, one negative skip, odd pointer (R11)
        load_ptr(0, 24'h001001); load_ptr(1, 24'h002000);
        load_ptr(2, 24'h003000); load_ptr(3, 24'h003000);
        load_mod(0, 16'h0004); load_mod(1, 16'hFFFA);
        load_mod(2, 16'h0027); load_mod(3, 16'h0026);
        run_blit(4'hF, 1'b0, {10'd3, 6'd2}, 0, "abcd-asc");

        // R6: descending A+D
        load_ptr(0, 24'h0040FE); load_ptr(3, 24'h0050FE);
        load_mod(0, 16'h0008); load_mod(3, 16'h0010);
        run_blit(4'b1001, 1'b1, {10'd4, 6'd3}, 0, "ad-desc");

        // R2: zero width field -> 64 words, zero height field -> 1024 rows
        run_blit(4'b1000, 1'b0, {10'd1, 6'd0}, 0, "w-max");
        run_blit(4'b1000, 1'b0, {10'd0, 6'd1}, 0, "h-max");

        // R9: continue from advanced pointers without reload
        run_blit(4'b0110, 1'b0, {10'd2, 6'd2}, 0, "cont1");
        run_blit(4'b0110, 1'b0, {10'd2, 6'd2}, 0, "cont2");

        // R10: writes while busy ignored
        run_blit(4'b1011, 1'b0, {10'd3, 6'd3}, 1, "inject");

        // random walks
        for (int k = 0; k < 24; k++) begin
            logic [3:0] en;
            en = 4'($urandom % 15 + 1);
            for (int c = 0; c < 4; c++) begin
                load_ptr(c, 24'($urandom));
                load_mod(c, 16'($urandom % 64) - 16'd32);
            end
            run_blit(en, 1'($urandom % 2),
                     {10'($urandom % 6 + 1), 6'($urandom % 8 + 1)}, 0, "rand");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule